// File: doc/BRIEF.md
# Video Component Gain and Setup Stage

This block is one pipelined stage in a standard-definition video path. It takes 4:4:4 luma and colour-difference samples (Y, Cb, Cr, 10 bits each) marked by a valid flag. It applies a separate programmable fixed-point gain to each component. On the luma path it can also limit the scaled value to a legal ceiling and then add a signed brightness offset. All three channels leave the block with the same two-cycle latency, and the valid flag is delayed to match.

Software programs the block through a simple byte-wide write port. Control bits, gains and the offset land in staging registers. They move into the working set only on a frame-synchronising strobe, so the processing never changes partway through a line. A gain is a 10-bit value in which 512 stands for unity. Its eight upper bits have one register per component, and the two low bits of all three gains share a single register.

Top module: `comp_gain_setup`

## Requirements
- R1: After reset, outVld is low and the outputs are zero. The working set has scaling, saturation and brightness off, every gain at 512, and an offset of 0.
- R2: With control bit 0 clear, Cb and Cr come out equal to their inputs. With bits 0, 1 and 3 all clear, Y also comes out equal to its input.
- R3: With bit 0 set, Y out = floor((Y·G + 256) / 512), where G is the 10-bit luma gain.
- R4: With bit 0 set, each chroma output = clip(512 + floor(((C − 512)·G + 256) / 512)) to 0..1023. A gain of 512 leaves the sample unchanged.
- R5: Gain layout. Address 2 holds the Y gain bits [9:2], address 3 the Cb gain bits [9:2] and address 4 the Cr gain bits [9:2]. Address 1 holds Y bits[1:0] in data bits [1:0], Cb in [3:2] and Cr in [5:4]. Writing 0xA6 to addresses 2–4 and 0x2A to address 1 gives a gain of 666 (factor 1.3) on every channel.
- R6: Control register (address 0) bit 1 limits the luma to 940 before the offset is added. This applies to the scaled luma, or to the raw luma when bit 0 is clear.
- R7: Control bit 3 adds data bits [6:0] of address 5, read as two's complement (−64..+63), to the luma. The sum is clipped to 0..1023, and bit 7 of that register has no effect.
- R8: Writes change nothing until a cycle with frameSync high. After that cycle the last written values are in force. A write in the same cycle as frameSync waits for the next strobe.
- R9: A sample accepted at one rising edge appears on the outputs after the second rising edge that follows. outVld repeats inVld with the same two-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Register write data |
| frameSync | input | 1 | Moves the staged settings into the working set |
| inVld | input | 1 | Input sample valid |
| inY | input | 10 | Luma in |
| inCb | input | 10 | Blue colour difference in, offset binary |
| inCr | input | 10 | Red colour difference in, offset binary |
| outVld | output | 1 | Output sample valid |
| outY | output | 10 | Adjusted luma |
| outCb | output | 10 | Adjusted Cb |
| outCr | output | 10 | Adjusted Cr |

## Verification
The assertions check several properties on every cycle:
- the working settings hold steady between strobes;
- the valid flag follows its pipeline;
- samples pass unchanged when scaling is off;
- a unity chroma gain is transparent;
- the luma never exceeds the ceiling when only saturation is on.

The arithmetic needs the bench's scenarios. These cover rounding of fractional products, chroma clipping at both rails, the sign of the brightness field with its ignored top bit, and the ordering of the ceiling before the offset. The scenarios also show that staged writes stay invisible until the strobe.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam int DATA_W   = 10;
  localparam int GAIN_W   = 10;
  localparam int FRAC_W   = 9;
  localparam int BRIGHT_W = 7;
  localparam int ADDR_W   = 4;
  localparam int REG_W    = 8;
  localparam int LUMA_MAX = 940;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_GLSB = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_GY   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_GCB  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_GCR  = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_BRT  = 4'd5;

  typedef struct packed {
    logic                       scaleEn;
    logic                       satEn;
    logic                       brightEn;
    logic [GAIN_W-1:0]          gainY;
    logic [GAIN_W-1:0]          gainCb;
    logic [GAIN_W-1:0]          gainCr;
    logic signed [BRIGHT_W-1:0] bright;
  } vgs_cfg_t;
endpackage

// File: rtl/vgs_regs.sv
module vgs_regs
  import vgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              frameSync,
  output vgs_cfg_t          cfg
);
  localparam int LSB_W = GAIN_W - REG_W;
  localparam logic [REG_W-1:0] UNITY_MSB = REG_W'(1 << (FRAC_W - LSB_W));

  logic [REG_W-1:0] ctrlStage, lsbStage, yStage, cbStage, crStage, brtStage;
  vgs_cfg_t         nextCfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlStage <= '0;
      lsbStage  <= '0;
      yStage    <= UNITY_MSB;
      cbStage   <= UNITY_MSB;
      crStage   <= UNITY_MSB;
      brtStage  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL: ctrlStage <= regWrData;
        ADDR_GLSB: lsbStage  <= regWrData;
        ADDR_GY:   yStage    <= regWrData;
        ADDR_GCB:  cbStage   <= regWrData;
        ADDR_GCR:  crStage   <= regWrData;
        ADDR_BRT:  brtStage  <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    nextCfg.scaleEn  = ctrlStage[0];
    nextCfg.satEn    = ctrlStage[1];
    nextCfg.brightEn = ctrlStage[3];
    nextCfg.gainY    = {yStage,  lsbStage[LSB_W-1:0]};
    nextCfg.gainCb   = {cbStage, lsbStage[2*LSB_W-1:LSB_W]};
    nextCfg.gainCr   = {crStage, lsbStage[3*LSB_W-1:2*LSB_W]};
    nextCfg.bright   = $signed(brtStage[BRIGHT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.scaleEn  <= 1'b0;
      cfg.satEn    <= 1'b0;
      cfg.brightEn <= 1'b0;
      cfg.gainY    <= GAIN_W'(1 << FRAC_W);
      cfg.gainCb   <= GAIN_W'(1 << FRAC_W);
      cfg.gainCr   <= GAIN_W'(1 << FRAC_W);
      cfg.bright   <= '0;
    end else if (frameSync) begin
      cfg <= nextCfg;
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !frameSync |=> $stable(cfg)); // R8
endmodule

// File: rtl/vgs_chroma_lane.sv
module vgs_chroma_lane #(
  parameter int DW   = 10,
  parameter int GW   = 10,
  parameter int FRAC = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sampleIn,
  input  logic [GW-1:0] gain,
  input  logic          scaleEn,
  output logic [DW-1:0] sampleOut
);
  localparam int CENTER = 1 << (DW - 1);
  localparam int MAXV   = (1 << DW) - 1;
  localparam int SW     = DW + 1;
  localparam int PW     = SW + GW + 1;
  localparam int RW     = PW - FRAC;

  logic signed [SW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [RW-1:0] rounded;
  logic signed [RW-1:0] stage1;
  logic signed [RW:0]   recentred;

  always_comb begin
    diff    = $signed({1'b0, sampleIn}) - $signed(SW'(CENTER));
    prod    = PW'(diff) * PW'($signed({1'b0, gain}));
    rounded = RW'((prod + $signed(PW'(1 << (FRAC - 1)))) >>> FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst) stage1 <= '0;
    else     stage1 <= scaleEn ? rounded : RW'(diff);
  end

  assign recentred = (RW+1)'(stage1) + $signed((RW+1)'(CENTER));

  always_ff @(posedge clk) begin
    if (rst)                                   sampleOut <= '0;
    else if (recentred < 0)                    sampleOut <= '0;
    else if (recentred > $signed((RW+1)'(MAXV))) sampleOut <= DW'(MAXV);
    else                                       sampleOut <= recentred[DW-1:0];
  end

  AST_CHROMA_UNITY: assert property (@(posedge clk) disable iff (rst)
    (scaleEn && gain == GW'(1 << FRAC)) |=> ##1 (sampleOut == $past(sampleIn, 2))); // R4
endmodule

// File: rtl/vgs_datapath.sv
module vgs_datapath
  import vgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  vgs_cfg_t          cfg,
  input  logic              inVld,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outVld,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outCb,
  output logic [DATA_W-1:0] outCr
);
  localparam int YPW  = DATA_W + GAIN_W;
  localparam int YRW  = YPW - FRAC_W;
  localparam int SUMW = YRW + 2;
  localparam int MAXV = (1 << DATA_W) - 1;
  localparam int NCH  = 2;

  logic [YPW-1:0]             yProd;
  logic [YRW-1:0]             yScaled, y1, yClamped;
  logic signed [SUMW-1:0]     ySum;
  logic                       vld1, sat1, bright1;
  logic signed [BRIGHT_W-1:0] brt1;

  always_comb begin
    yProd   = YPW'(inY) * YPW'(cfg.gainY);
    yScaled = YRW'((yProd + YPW'(1 << (FRAC_W - 1))) >> FRAC_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1 <= 1'b0; y1 <= '0; sat1 <= 1'b0; bright1 <= 1'b0; brt1 <= '0;
    end else begin
      vld1    <= inVld;
      y1      <= cfg.scaleEn ? yScaled : YRW'(inY);
      sat1    <= cfg.satEn;
      bright1 <= cfg.brightEn;
      brt1    <= cfg.bright;
    end
  end

  always_comb begin
    yClamped = (sat1 && y1 > YRW'(LUMA_MAX)) ? YRW'(LUMA_MAX) : y1;
    ySum     = $signed({2'b00, yClamped}) + (bright1 ? SUMW'(brt1) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outVld <= 1'b0;
      outY   <= '0;
    end else begin
      outVld <= vld1;
      if (ySum < 0)                            outY <= '0;
      else if (ySum > $signed(SUMW'(MAXV)))    outY <= DATA_W'(MAXV);
      else                                     outY <= ySum[DATA_W-1:0];
    end
  end

  logic [DATA_W-1:0] laneIn   [NCH];
  logic [GAIN_W-1:0] laneGain [NCH];
  logic [DATA_W-1:0] laneOut  [NCH];

  assign laneIn[0]   = inCb;
  assign laneIn[1]   = inCr;
  assign laneGain[0] = cfg.gainCb;
  assign laneGain[1] = cfg.gainCr;
  assign outCb       = laneOut[0];
  assign outCr       = laneOut[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : gLane
    vgs_chroma_lane #(.DW(DATA_W), .GW(GAIN_W), .FRAC(FRAC_W)) uLane (
      .clk(clk), .rst(rst), .sampleIn(laneIn[ch]), .gain(laneGain[ch]),
      .scaleEn(cfg.scaleEn), .sampleOut(laneOut[ch]));
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vld1 |=> outVld); // R9
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst)
    !vld1 |=> !outVld); // R9
  AST_Y_PASS: assert property (@(posedge clk) disable iff (rst)
    (!cfg.scaleEn && !cfg.satEn && !cfg.brightEn) |=> ##1 (outY == $past(inY, 2))); // R2
  AST_CB_PASS: assert property (@(posedge clk) disable iff (rst)
    !cfg.scaleEn |=> ##1 (outCb == $past(inCb, 2))); // R2
  AST_SAT_CEIL: assert property (@(posedge clk) disable iff (rst)
    (cfg.satEn && !cfg.brightEn) |=> ##1 (outY <= DATA_W'(LUMA_MAX))); // R6
endmodule

// File: rtl/comp_gain_setup.sv
module comp_gain_setup
  import vgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              frameSync,
  input  logic              inVld,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outVld,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outCb,
  output logic [DATA_W-1:0] outCr
);
  vgs_cfg_t cfg;

  vgs_regs uRegs (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameSync(frameSync), .cfg(cfg));

  vgs_datapath uPath (
    .clk(clk), .rst(rst), .cfg(cfg), .inVld(inVld), .inY(inY),
    .inCb(inCb), .inCr(inCr), .outVld(outVld), .outY(outY),
    .outCb(outCb), .outCr(outCr));
endmodule

// File: tb/comp_gain_setup_test.sv
`timescale 1ns/1ps
module comp_gain_setup_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       frameSync = 1'b0;
  logic       inVld = 1'b0;
  logic [9:0] inY = '0, inCb = '0, inCr = '0;
  logic       outVld;
  logic [9:0] outY, outCb, outCr;

  int checks = 0;
  int fails  = 0;

  // Model settings held by the bench, mirroring what was programmed
  int mCtrl = 0, mGy = 512, mGcb = 512, mGcr = 512, mBrt = 0;

  always #2 clk = ~clk;

  comp_gain_setup uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameSync(frameSync), .inVld(inVld),
    .inY(inY), .inCb(inCb), .inCr(inCr), .outVld(outVld),
    .outY(outY), .outCb(outCb), .outCr(outCr));

  // Stimulus table: {Y, Cb, Cr}
  localparam logic [29:0] VEC [8] = '{
    {10'd0,    10'd512,  10'd512},
    {10'd400,  10'd700,  10'd300},
    {10'd1023, 10'd1023, 10'd0},
    {10'd64,   10'd513,  10'd511},
    {10'd700,  10'd900,  10'd100},
    {10'd940,  10'd0,    10'd1023},
    {10'd1,    10'd600,  10'd450},
    {10'd512,  10'd256,  10'd768}
  };

  function automatic int clip(int v);
    return (v < 0) ? 0 : (v > 1023) ? 1023 : v;
  endfunction

  function automatic int expY(int y);
    int v, b;
    v = mCtrl[0] ? ((y * mGy + 256) >>> 9) : y;
    if (mCtrl[1] && v > 940) v = 940;
    b = mBrt & 127;
    if (b >= 64) b = b - 128;
    if (mCtrl[3]) v = v + b;
    return clip(v);
  endfunction

  function automatic int expC(int c, int g);
    int d;
    d = c - 512;
    if (mCtrl[0]) d = (d * g + 256) >>> 9;
    return clip(512 + d);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(addr); regWrData = 8'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sync();
    @(negedge clk);
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
  endtask

  task automatic setGains(int gy, int gcb, int gcr);
    wr(2, gy >> 2);
    wr(3, gcb >> 2);
    wr(4, gcr >> 2);
    wr(1, ((gcr & 3) << 4) | ((gcb & 3) << 2) | (gy & 3));
  endtask

  // Drives one sample and returns at the negedge after its output edge
  task automatic send(int y, int cb, int cr);
    @(negedge clk);
    inVld = 1'b1; inY = 10'(y); inCb = 10'(cb); inCr = 10'(cr);
    @(negedge clk);
    inVld = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendCheck(string tag, int y, int cb, int cr);
    send(y, cb, cr);
    chk({tag, " Y"},  int'(outY),  expY(y));
    chk({tag, " Cb"}, int'(outCb), expC(cb, mGcb));
    chk({tag, " Cr"}, int'(outCr), expC(cr, mGcr));
  endtask

  task automatic runTable(string tag);
    for (int i = 0; i < 8; i++)
      sendCheck(tag, int'(VEC[i][29:20]), int'(VEC[i][19:10]), int'(VEC[i][9:0]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outVld", int'(outVld), 0);
    chk("R1 reset outY", int'(outY), 0);
    chk("R1 reset outCb", int'(outCb), 0);
    rst = 1'b0;

    // R1/R2: default working set passes samples through
    sendCheck("R1 R2 default pass", 1000, 77, 999);

    // R8: staged writes invisible before the strobe
    wr(2, 8'hA6); wr(3, 8'hA6); wr(4, 8'hA6); wr(1, 8'h2A); wr(0, 8'h01);
    send(400, 700, 300);
    chk("R8 pre-sync Y", int'(outY), 400);
    chk("R8 pre-sync Cb", int'(outCb), 700);
    sync();
    // R5/R3/R4: factor 1.3 packed as 0xA6/0x2A gives 666 on every channel
    mCtrl = 1; mGy = 666; mGcb = 666; mGcr = 666;
    send(400, 700, 300);
    chk("R5 R3 Y 1.3", int'(outY), 520);
    chk("R5 R4 Cb 1.3", int'(outCb), 757);
    chk("R5 R4 Cr 1.3", int'(outCr), 236);

    // R3/R4/R6/R7 table with all features enabled
    setGains(666, 1023, 256); wr(5, 8'h28); wr(0, 8'h0B); sync();
    mCtrl = 'h0B; mGy = 666; mGcb = 1023; mGcr = 256; mBrt = 'h28;
    runTable("R3 R4 R6 R7 tableA");

    // R3/R4 table with scaling only, zero and unity chroma gain
    setGains(768, 0, 512); wr(0, 8'h01); sync();
    mCtrl = 1; mGy = 768; mGcb = 0; mGcr = 512;
    runTable("R3 R4 tableB");

    // R4 chroma clipping at both rails with near-2.0 gain
    setGains(512, 1023, 1023); sync();
    mGy = 512; mGcb = 1023; mGcr = 1023;
    send(10, 1023, 0);
    chk("R4 clip high Cb", int'(outCb), 1023);
    chk("R4 clip low Cr", int'(outCr), 0);

    // R6: ceiling on scaled luma, then offset applied after it
    setGains(768, 512, 512); wr(0, 8'h03); sync();
    mCtrl = 3; mGy = 768;
    send(1000, 512, 512);
    chk("R6 ceiling", int'(outY), 940);
    send(600, 512, 512);
    chk("R6 below ceiling", int'(outY), 900);
    wr(5, 8'h28); wr(0, 8'h0B); sync();
    send(1000, 512, 512);
    chk("R6 R7 ceiling then offset", int'(outY), 980);

    // R7: negative offset, top bit ignored, clip at both ends
    wr(0, 8'h08); wr(5, 8'hD8); sync();
    mCtrl = 8; mBrt = 'hD8;
    send(20, 512, 512);
    chk("R7 negative clip to 0", int'(outY), 0);
    send(500, 512, 512);
    chk("R7 -40 with bit7 ignored", int'(outY), 460);
    wr(5, 8'hA8); sync();
    send(1000, 512, 512);
    chk("R7 +40 bit7 ignored clip 1023", int'(outY), 1023);

    // R8: write in the strobe cycle waits for the next strobe
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd5; regWrData = 8'h00; frameSync = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; frameSync = 1'b0;
    send(500, 512, 512);
    chk("R8 same-cycle write deferred", int'(outY), 540);
    sync();
    send(500, 512, 512);
    chk("R8 next strobe applies", int'(outY), 500);

    // R9: latency and valid alignment
    @(negedge clk);
    inVld = 1'b1; inY = 10'd123; inCb = 10'd512; inCr = 10'd512;
    @(negedge clk);
    inVld = 1'b0;
    chk("R9 not valid after one edge", int'(outVld), 0);
    @(negedge clk);
    chk("R9 valid after two edges", int'(outVld), 1);
    chk("R9 data after two edges", int'(outY), 123);
    @(negedge clk);
    chk("R9 valid drops", int'(outVld), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule